// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer Bank

The block holds five independent down-counting timers behind a word-addressed register port. Channels 0 to 3 each drive one pulse-width-modulated output, and channel 4 is a plain countdown timer with no output. Every channel has its own tick-enable input, which is driven by a prescaler outside this block. A counter moves only on a clock edge where its tick enable is high.

Software does not write the running counters directly. It writes a count buffer, and on channels 0 to 3 also a compare buffer. These values reach the working registers in one of two ways: the channel's manual-update control bit is held set, or an auto-reload happens when the counter reaches zero. A live-count word per channel lets software observe the counter. Each channel raises a one-cycle interrupt pulse on the edge where its counter reaches zero.

Top module: `pwm_timer_bank`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every working count and compare is 0, the control word and all buffers read 0, and pwm_out and irq are all 0.
- R2: Word 0 is the control word. For channel n, the count buffer sits at word 1+3n, the compare buffer at 2+3n and the live count at 3+3n. A read issued with rd_en is returned on rd_data with rd_valid high one cycle later. Control bits with no function (4 to 11 and 27 to 31) always read 0.
- R3: Writing a count or compare buffer leaves the working count unchanged until the next load. Writes to a live-count word are ignored.
- R4: On every edge where a channel's manual-update bit is set, its working count and compare are loaded from the buffers, and the channel does not count.
- R5: With its start bit set and its tick enable high, a channel's count drops by exactly 1 per edge. At zero it stays at zero unless auto-reload is set.
- R6: With start clear or the tick enable low, the working count holds its value.
- R7: irq[n] is high for exactly one cycle, following the edge where channel n's count goes from 1 to 0.
- R8: With auto-reload set, a channel at zero reloads count and compare from the buffers on its next tick. The spacing between interrupts is therefore count buffer + 1 ticks, and a buffer value written during a period takes effect at the next reload.
- R9: pwm_out[n] (n = 0 to 3) is 1 while the working count is greater than the working compare, XOR-ed with the channel's invert bit. Control bits for channel n sit at bit 0 for n = 0 and at bit 8+4n for n = 1 to 3, in the order start, update, invert, auto-reload.
- R10: Channel 4 uses start at bit 24, update at bit 25 and auto-reload at bit 26. It has no compare: word 14 reads 0 and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 5 | Per-channel count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| pwm_out | output | 4 | PWM outputs of channels 0 to 3 |
| irq | output | 5 | Per-channel zero-reached pulse |

## Verification
The hardest situation to reach from the ports is a buffer write that lands while an auto-reloading channel is mid-period. This write must have no effect until the following reload, and the interrupt spacing should then change from the old to the new period. The stimulus first locks onto a channel's interrupt pulse and measures the spacing over two periods. It then rewrites the count buffer and resynchronises on the next pulse, so that the following spacing must show the new value. A similar problem arises with a running counter that is frozen by holding manual update, then released and stopped after a known number of edges. The stimulus spaces those writes so that the final live count is exact.

// File: rtl/pwm_bank_pkg.sv
// Package: shared constants and helpers for the PWM timer bank.
// Assumes four PWM channels plus one output-less timer, and a 32-bit data word.
package pwm_bank_pkg;

    localparam int STRIDE   = 3;    // words per channel
    localparam int SLOT_CNT = 0;
    localparam int SLOT_CMP = 1;
    localparam int SLOT_OBS = 2;

    // Field order inside a PWM channel's 4-bit control group
    localparam int F_START = 0;
    localparam int F_UPD   = 1;
    localparam int F_INV   = 2;
    localparam int F_ARL   = 3;

    // Timer-only channel control bits
    localparam int T_START = 24;
    localparam int T_UPD   = 25;
    localparam int T_ARL   = 26;

    // Lowest control bit of PWM channel n
    function automatic int grp_base(int n);
        return (n == 0) ? 0 : 8 + 4 * n;
    endfunction

    // Word address of a channel slot
    function automatic int buf_addr(int n, int slot);
        return 1 + STRIDE * n + slot;
    endfunction

    // Mask of implemented control bits
    function automatic logic [31:0] ctrl_mask_f(int npwm);
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < npwm; n++) m[grp_base(n) +: 4] = 4'hF;
        m[T_START] = 1'b1;
        m[T_UPD]   = 1'b1;
        m[T_ARL]   = 1'b1;
        return m;
    endfunction

    // A running channel at zero with auto-reload set reloads on its tick
    function automatic logic reload_due(logic start, logic tick, logic arl, logic zero);
        return start & tick & arl & zero;
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
// Register file: control word, count/compare buffers and a registered read port.
// Assumes control-bit layout from pwm_bank_pkg; live counts come from the counters.
module pwm_regfile
    import pwm_bank_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int NUM_PWM = 4,
    localparam int NUM_CH = NUM_PWM + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [DATA_W-1:0]              wr_data,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_CH-1:0][DATA_W-1:0]  live_cnt,
    output logic [NUM_CH-1:0]              start_o,
    output logic [NUM_CH-1:0]              upd_o,
    output logic [NUM_CH-1:0]              arl_o,
    output logic [NUM_PWM-1:0]             inv_o,
    output logic [NUM_CH-1:0][DATA_W-1:0]  cnt_buf_o,
    output logic [NUM_PWM-1:0][DATA_W-1:0] cmp_buf_o,
    output logic [DATA_W-1:0]              rd_data,
    output logic                           rd_valid
);
    localparam logic [31:0] CTRL_MASK = ctrl_mask_f(NUM_PWM);
    localparam int          TMR       = NUM_PWM;

    logic [31:0]              ctrl_q;
    logic [NUM_CH-1:0][DATA_W-1:0]  cnt_buf_q;
    logic [NUM_PWM-1:0][DATA_W-1:0] cmp_buf_q;
    logic [DATA_W-1:0]        rd_next;

    // Control word write, keeping only implemented bits
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (wr_en && wr_addr == '0)     ctrl_q <= 32'(wr_data) & CTRL_MASK;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_cnt_buf
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(buf_addr(n, SLOT_CNT));
        // Count buffer write for channel n
        always_ff @(posedge clk) begin
            if (!rst_n)                         cnt_buf_q[n] <= '0;
            else if (wr_en && wr_addr == A_CNT) cnt_buf_q[n] <= wr_data;
        end
    end

    for (genvar n = 0; n < NUM_PWM; n++) begin : g_pwm_ctl
        localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(buf_addr(n, SLOT_CMP));
        // Compare buffer write for channel n
        always_ff @(posedge clk) begin
            if (!rst_n)                         cmp_buf_q[n] <= '0;
            else if (wr_en && wr_addr == A_CMP) cmp_buf_q[n] <= wr_data;
        end
        assign start_o[n] = ctrl_q[grp_base(n) + F_START];
        assign upd_o[n]   = ctrl_q[grp_base(n) + F_UPD];
        assign inv_o[n]   = ctrl_q[grp_base(n) + F_INV];
        assign arl_o[n]   = ctrl_q[grp_base(n) + F_ARL];
    end

    assign start_o[TMR] = ctrl_q[T_START];
    assign upd_o[TMR]   = ctrl_q[T_UPD];
    assign arl_o[TMR]   = ctrl_q[T_ARL];
    assign cnt_buf_o    = cnt_buf_q;
    assign cmp_buf_o    = cmp_buf_q;

    // Read decode; unmapped words return zero
    always_comb begin
        rd_next = '0;
        if (rd_addr == '0) rd_next = DATA_W'(ctrl_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (rd_addr == ADDR_W'(buf_addr(n, SLOT_CNT))) rd_next = cnt_buf_q[n];
            if (rd_addr == ADDR_W'(buf_addr(n, SLOT_OBS))) rd_next = live_cnt[n];
        end
        for (int n = 0; n < NUM_PWM; n++) begin
            if (rd_addr == ADDR_W'(buf_addr(n, SLOT_CMP))) rd_next = cmp_buf_q[n];
        end
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
        end
    end

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);                                   // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);                                 // R2

endmodule

// File: rtl/pwm_down_counter.sv
// One channel's working counter: buffer load, down count, auto-reload, zero pulse.
// Assumes tick is a one-cycle enable from an external prescaler.
module pwm_down_counter
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             upd,
    input  logic             arl,
    input  logic [CNT_W-1:0] cnt_buf,
    output logic [CNT_W-1:0] cnt_o,
    output logic             irq_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;
    logic             zero;

    assign zero = (cnt_q == '0);

    // Counter update: manual load wins, then reload at zero, then decrement
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (upd) begin
                cnt_q <= cnt_buf;
            end else if (reload_due(start, tick, arl, zero)) begin
                cnt_q <= cnt_buf;
            end else if (start && tick && !zero) begin
                cnt_q <= cnt_q - 1'b1;
                irq_q <= (cnt_q == CNT_W'(1));
            end
        end
    end

    assign cnt_o = cnt_q;
    assign irq_o = irq_q;

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q);                                     // R7
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> zero);                                       // R7
    AST_UPD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> cnt_q == $past(cnt_buf));                      // R4
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !(start && tick)) |=> $stable(cnt_q));        // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && start && tick && !zero) |=> cnt_q == $past(cnt_q) - 1'b1); // R5

endmodule

// File: rtl/pwm_compare.sv
// Working compare register and output level for one PWM channel.
// Assumes it sees the same control inputs and live count as its counter.
module pwm_compare
    import pwm_bank_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             upd,
    input  logic             arl,
    input  logic             inv,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_buf,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cmp_q;

    // Compare load on manual update or auto-reload, in step with the counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmp_q <= '0;
        else if (upd || reload_due(start, tick, arl, cnt == '0))
            cmp_q <= cmp_buf;
    end

    assign pwm_o = (cnt > cmp_q) ^ inv;

    AST_CMP_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> cmp_q == $past(cmp_buf));                      // R4
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (pwm_o == inv));                       // R9

endmodule

// File: rtl/pwm_timer_bank.sv
// Top: register file plus four PWM channels and one output-less countdown timer.
// Assumes tick_en comes from a separate prescaler; no bus bridging here.
module pwm_timer_bank
    import pwm_bank_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_PWM = 4,
    localparam int NUM_CH = NUM_PWM + 1,
    localparam int ADDR_W = $clog2(1 + STRIDE * NUM_CH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CH-1:0]  tick_en,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_valid,
    output logic [NUM_PWM-1:0] pwm_out,
    output logic [NUM_CH-1:0]  irq
);
    logic [NUM_CH-1:0]              start, upd, arl;
    logic [NUM_PWM-1:0]             inv;
    logic [NUM_CH-1:0][DATA_W-1:0]  cnt_buf, live_cnt;
    logic [NUM_PWM-1:0][DATA_W-1:0] cmp_buf;

    pwm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_PWM(NUM_PWM)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .live_cnt(live_cnt),
        .start_o(start), .upd_o(upd), .arl_o(arl), .inv_o(inv),
        .cnt_buf_o(cnt_buf), .cmp_buf_o(cmp_buf),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        pwm_down_counter #(.CNT_W(DATA_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .tick(tick_en[n]),
            .start(start[n]), .upd(upd[n]), .arl(arl[n]),
            .cnt_buf(cnt_buf[n]), .cnt_o(live_cnt[n]), .irq_o(irq[n])
        );
        if (n < NUM_PWM) begin : g_out
            pwm_compare #(.CNT_W(DATA_W)) u_cmp (
                .clk(clk), .rst_n(rst_n), .tick(tick_en[n]),
                .start(start[n]), .upd(upd[n]), .arl(arl[n]), .inv(inv[n]),
                .cnt(live_cnt[n]), .cmp_buf(cmp_buf[n]), .pwm_o(pwm_out[n])
            );
        end
    end

endmodule

// File: tb/sim_pwm_timer_bank.sv
// Scoreboard bench: read tasks queue expected values, a monitor compares returns.
module sim_pwm_timer_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick_en = 5'b11111;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [3:0]  pwm_out;
    logic [4:0]  irq;

    int checks = 0, fails = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] ctl = '0;

    always #5 clk = ~clk;

    pwm_timer_bank u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
        .pwm_out(pwm_out), .irq(irq)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk); rd_en = 1'b0;
    endtask

    // Edges until the next irq pulse on channel ch, sampled at the falling edge
    task automatic wait_irq(input int ch, output int k);
        k = 0;
        do begin
            @(posedge clk); k++;
            @(negedge clk);
        end while (!irq[ch] && k < 100);
    endtask

    // Monitor: pop expected read values as results come back
    always @(negedge clk) begin
        if (rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R2: read returned %0d with nothing expected", rd_data);
            end else begin
                check(rd_data, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int k, highs;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(32'(pwm_out), 0, "R1 pwm_out");
        check(32'(irq), 0, "R1 irq");
        rd(0, 0, "R1 ctrl");
        rd(3, 0, "R1 live0");

        // R3 buffer writes do not reach the counter; R2 readback
        wr(1, 5); wr(2, 2);
        rd(3, 0, "R3 live0 untouched");
        rd(1, 5, "R2 cnt buf0");
        rd(2, 2, "R2 cmp buf0");

        // R4 manual update
        ctl = 32'h2; wr(0, ctl);
        ctl = 32'h0; wr(0, ctl);
        rd(3, 5, "R4 live0 loaded");
        check(32'(pwm_out[0]), 1, "R9 count above compare");

        // R5/R7/R9 one-shot run from 5 with compare 2
        ctl = 32'h1; wr(0, ctl);
        highs = int'(pwm_out[0]);
        k = 0;
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (irq[0]) break;
            highs += int'(pwm_out[0]);
        end
        check(32'(k), 5, "R5 edges to zero");
        check(32'(highs), 3, "R9 high ticks");
        @(negedge clk);
        check(32'(irq[0]), 0, "R7 pulse width");
        rd(3, 0, "R5 stays at zero");

        // R9 invert
        ctl = ctl | 32'h4; wr(0, ctl);
        check(32'(pwm_out[0]), 1, "R9 inverted idle");
        ctl = ctl & ~32'h4; wr(0, ctl);
        check(32'(pwm_out[0]), 0, "R9 normal idle");

        // R8 auto-reload on channel 1, period change at reload
        wr(4, 3); wr(5, 1);
        ctl = ctl | (32'h1 << 13); wr(0, ctl);
        ctl = ctl & ~(32'h1 << 13); wr(0, ctl);
        ctl = ctl | (32'h1 << 12) | (32'h1 << 15); wr(0, ctl);
        wait_irq(1, k);
        wait_irq(1, k); check(32'(k), 4, "R8 period 3+1");
        wait_irq(1, k); check(32'(k), 4, "R8 period repeat");
        wr(4, 6);
        rd(4, 6, "R3 buffer written while running");
        wait_irq(1, k);
        wait_irq(1, k); check(32'(k), 7, "R8 new period 6+1");

        // R4 hold while update set, R6 stop holds count (channel 2)
        wr(7, 10); wr(8, 0);
        ctl = ctl | (32'h1 << 16) | (32'h1 << 17); wr(0, ctl);
        repeat (4) @(negedge clk);
        rd(9, 10, "R4 update holds count");
        ctl = ctl & ~(32'h1 << 17); wr(0, ctl);
        ctl = ctl & ~(32'h1 << 16); wr(0, ctl);
        repeat (3) @(negedge clk);
        rd(9, 8, "R6 stopped count");
        repeat (3) @(negedge clk);
        rd(9, 8, "R6 still stopped");

        // R6 tick gating, R5 exact tick count (channel 3)
        tick_en[3] = 1'b0;
        wr(10, 7); wr(11, 0);
        ctl = ctl | (32'h1 << 21); wr(0, ctl);
        ctl = ctl & ~(32'h1 << 21); wr(0, ctl);
        ctl = ctl | (32'h1 << 20); wr(0, ctl);
        repeat (5) @(negedge clk);
        rd(12, 7, "R6 no tick no count");
        @(negedge clk); tick_en[3] = 1'b1;
        @(negedge clk); @(negedge clk); tick_en[3] = 1'b0;
        repeat (2) @(negedge clk);
        rd(12, 5, "R5 two ticks");
        check(32'(pwm_out[3]), 1, "R9 channel 3 level");

        // R10 timer channel
        wr(14, 99);
        rd(14, 0, "R10 no compare word");
        wr(13, 2);
        ctl = ctl | (32'h1 << 25); wr(0, ctl);
        ctl = ctl & ~(32'h1 << 25); wr(0, ctl);
        rd(15, 2, "R10 timer loaded");
        ctl = ctl | (32'h1 << 24); wr(0, ctl);
        wait_irq(4, k); check(32'(k), 2, "R10 timer one-shot");
        ctl = ctl | (32'h1 << 26); wr(0, ctl);
        wait_irq(4, k);
        wait_irq(4, k); check(32'(k), 3, "R8 timer reload period");

        // R2 control readback, reserved bits read zero
        rd(0, ctl, "R2 ctrl readback");
        wr(0, ctl | 32'hF800_0FF0);
        rd(0, ctl, "R2 reserved bits zero");

        // R3 live-count word ignores writes
        wr(3, 123);
        rd(3, 0, "R3 live write ignored");
        rd(1, 5, "R3 buffer intact");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R2: actual %0d reads pending expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule